// File: doc/BRIEF.md
# Shaper Rate Parameter Converter

This unit converts a requested shaping rate, given in Mbps, into the three integer parameters of a token-bucket shaper: an 8-bit mantissa, an up-scaling exponent and a down-scaling exponent. The parameters obey `rate = mant * 2^up * 8 * 1000 / (tick * 2^down)`. Here `tick` is a constant chosen by the shaper level the parameters are meant for. The conversion is an iterative search around a fixed mantissa of 126. Each step runs one division on a shared restoring divider that produces one quotient bit per cycle.

A request is offered on `in_valid` together with `in_rate` and `in_level`. It is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle. While a conversion runs, `in_valid` has no effect. A requester that needs its request taken must hold it until `in_ready` rises. There is no back-pressure on the result side. The result appears for exactly one cycle with `out_valid`, and must be captured then.

Top module: `shp_rate_conv`

## Requirements
- R1: `in_ready` is 1 only while idle. A request is taken on an edge with `in_valid=1` and `in_ready=1`. Any request offered while busy is ignored: it produces no result and does not alter the running conversion.
- R2: Each taken request yields exactly one result cycle with `out_valid=1`. `out_valid` is never high on two consecutive cycles. `in_ready` returns to 1 on the cycle after the result.
- R3: A level value of 4 or above yields `out_err=1`, with `out_mant`, `out_up` and `out_down` all 0.
- R4: Tick per level: 1536 for level 0, 192 for level 1, 48 for level 2, 1536 for level 3. The baseline rate is `(1008000 + tick/2 - 1) / tick`, truncated. If it equals the request, the result is mant 126, up 0, down 0.
- R5: If the baseline is above the request, the down exponent steps 1, 2, 3, ... The rate is recomputed as `1008000 / (tick * 2^down)`, truncated, until it is not above the request.
- R6: After the down search, mant is 126 if the rate equals the request. Otherwise mant is `(req * tick * 2^down + 4000) / 8000`, truncated and then kept to its low 8 bits.
- R7: If the baseline is below the request, the up exponent steps 1, 2, 3, ... The rate is recomputed as `(1008000 * 2^up + tick/2) / tick`, truncated, until it is not below the request.
- R8: After the up search, mant is 126 if the rate equals the request. Otherwise the up exponent drops by one, and mant is `(req * tick + d/2) / d` with `d = 8000 * 2^up`, kept to its low 8 bits.
- R9: A search that reaches exponent 15 without meeting its stop condition yields `out_err=1`, with all parameters 0.
- R10: After reset, `in_ready=1` and `out_valid=0`. No result has both `out_up` and `out_down` nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_rate | input | 32 | Requested rate in Mbps |
| in_level | input | 3 | Shaper level (0..3 valid) |
| out_valid | output | 1 | One-cycle result strobe |
| out_mant | output | 8 | Mantissa |
| out_up | output | 4 | Up-scaling exponent |
| out_down | output | 4 | Down-scaling exponent |
| out_err | output | 1 | Level out of range or search did not converge |

## Verification
The bench goes after requests that hit each level's baseline exactly. A design with a wrong tick or a wrong baseline rounding would leave the 126/0/0 shortcut and report a nonzero exponent. It drives down-search cases, including a zero rate, and up-search cases whose final rate overshoots. There, a missing decrement of the up exponent, or rounding on the wrong side, shows up as a mantissa or exponent off by one step. Rates too large for exponent 15 and out-of-range levels check that the error path clears every parameter and does not hang. Requests offered while busy must leave the result untouched and must not cause a second result.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_SRCH_DN,
    ST_SRCH_UP,
    ST_MANT,
    ST_FIN
  } shp_state_e;

  // 126 * 8 * 1000: rate numerator with mantissa 126 and both exponents 0
  localparam int unsigned BASE_NUM_I = 1008000;
  localparam int unsigned MANT_FIX_I = 126;
  localparam int unsigned UNIT_DIV_I = 8000;
endpackage

// File: rtl/shp_tick_sel.sv
module shp_tick_sel #(
  parameter int N_LVL  = 4,
  parameter int LVL_W  = 3,
  parameter int TICK_W = 16,
  parameter logic [N_LVL*TICK_W-1:0] TICKS = '0
) (
  input  logic [LVL_W-1:0]  level,
  output logic [TICK_W-1:0] tick,
  output logic              lvl_ok
);
  logic [N_LVL-1:0]  hit;
  logic [TICK_W-1:0] part [N_LVL];

  for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
    assign hit[i]  = (int'(level) == i);
    assign part[i] = hit[i] ? TICKS[i*TICK_W +: TICK_W] : '0;
  end

  always_comb begin
    tick = '0;
    for (int i = 0; i < N_LVL; i++) tick = tick | part[i];
  end

  assign lvl_ok = |hit;
endmodule

// File: rtl/shp_restoring_div.sv
module shp_restoring_div #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_r, quo_r, den_r, num_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted, diff;
  logic          ge;

  assign shifted = {rem_r, quo_r[W-1]};
  assign ge      = shifted >= {1'b0, den_r};
  assign diff    = shifted - {1'b0, den_r};
  assign quo     = quo_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_r <= '0;
      quo_r <= '0;
      den_r <= '0;
      num_r <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_r <= '0;
        quo_r <= num;
        den_r <= den;
        num_r <= num;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        rem_r <= ge ? diff[W-1:0] : shifted[W-1:0];
        quo_r <= {quo_r[W-2:0], ge};
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  logic [2*W-1:0] prod;
  assign prod = {{W{1'b0}}, quo_r} * {{W{1'b0}}, den_r};

  // R4: every quotient handed to the sequencer is the truncated one
  assert_quot_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod <= {{W{1'b0}}, num_r}) &&
             ({{W{1'b0}}, num_r} - prod < {{W{1'b0}}, den_r}));
endmodule

// File: rtl/shp_rate_conv.sv
module shp_rate_conv #(
  parameter int RATE_W  = 32,
  parameter int LVL_W   = 3,
  parameter int N_LVL   = 4,
  parameter int TICK_W  = 16,
  parameter int MANT_W  = 8,
  parameter int EXP_W   = 4,
  parameter int EXP_MAX = 15,
  parameter int DW      = 48,
  parameter logic [N_LVL*TICK_W-1:0] TICKS = {16'd1536, 16'd48, 16'd192, 16'd1536}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RATE_W-1:0] in_rate,
  input  logic [LVL_W-1:0]  in_level,
  output logic              out_valid,
  output logic [MANT_W-1:0] out_mant,
  output logic [EXP_W-1:0]  out_up,
  output logic [EXP_W-1:0]  out_down,
  output logic              out_err
);
  import shp_pkg::*;

  localparam logic [DW-1:0]    BASE_NUM = DW'(BASE_NUM_I);
  localparam logic [DW-1:0]    UNIT_DIV = DW'(UNIT_DIV_I);
  localparam logic [DW-1:0]    HALF_DIV = DW'(UNIT_DIV_I / 2);
  localparam logic [MANT_W-1:0] MANT_FIX = MANT_W'(MANT_FIX_I);
  localparam logic [EXP_W-1:0]  EXP_TOP  = EXP_W'(EXP_MAX);

  shp_state_e        state;
  logic [TICK_W-1:0] tick;
  logic              lvl_ok;
  logic [DW-1:0]     req_r, tick_r;
  logic              div_go, div_done;
  logic [DW-1:0]     div_num, div_den, q;

  shp_tick_sel #(.N_LVL(N_LVL), .LVL_W(LVL_W), .TICK_W(TICK_W), .TICKS(TICKS)) tick_i (
    .level(in_level), .tick(tick), .lvl_ok(lvl_ok)
  );

  shp_restoring_div #(.W(DW)) div_i (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quo(q)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_r    <= '0;
      tick_r   <= '0;
      div_go   <= 1'b0;
      div_num  <= '0;
      div_den  <= '0;
      out_mant <= '0;
      out_up   <= '0;
      out_down <= '0;
      out_err  <= 1'b0;
    end else begin
      div_go <= 1'b0;
      case (state)
        ST_IDLE: if (in_valid) begin
          req_r    <= DW'(in_rate);
          out_mant <= '0;
          out_up   <= '0;
          out_down <= '0;
          out_err  <= 1'b0;
          if (!lvl_ok) begin
            out_err <= 1'b1;
            state   <= ST_FIN;
          end else begin
            tick_r  <= DW'(tick);
            div_go  <= 1'b1;
            div_num <= BASE_NUM + (DW'(tick) >> 1) - DW'(1);
            div_den <= DW'(tick);
            state   <= ST_BASE;
          end
        end
        ST_BASE: if (div_done) begin
          if (q == req_r) begin
            out_mant <= MANT_FIX;
            state    <= ST_FIN;
          end else if (q > req_r) begin
            out_down <= EXP_W'(1);
            div_go   <= 1'b1;
            div_num  <= BASE_NUM;
            div_den  <= tick_r << 1;
            state    <= ST_SRCH_DN;
          end else begin
            out_up  <= EXP_W'(1);
            div_go  <= 1'b1;
            div_num <= (BASE_NUM << 1) + (tick_r >> 1);
            div_den <= tick_r;
            state   <= ST_SRCH_UP;
          end
        end
        ST_SRCH_DN: if (div_done) begin
          if (q <= req_r) begin
            if (q == req_r) begin
              out_mant <= MANT_FIX;
              state    <= ST_FIN;
            end else begin
              div_go  <= 1'b1;
              div_num <= ((req_r * tick_r) << out_down) + HALF_DIV;
              div_den <= UNIT_DIV;
              state   <= ST_MANT;
            end
          end else if (out_down == EXP_TOP) begin
            out_err  <= 1'b1;
            out_down <= '0;
            state    <= ST_FIN;
          end else begin
            out_down <= out_down + EXP_W'(1);
            div_go   <= 1'b1;
            div_num  <= BASE_NUM;
            div_den  <= tick_r << (out_down + EXP_W'(1));
            state    <= ST_SRCH_DN;
          end
        end
        ST_SRCH_UP: if (div_done) begin
          if (q >= req_r) begin
            if (q == req_r) begin
              out_mant <= MANT_FIX;
              state    <= ST_FIN;
            end else begin
              out_up  <= out_up - EXP_W'(1);
              div_go  <= 1'b1;
              div_num <= (req_r * tick_r) + (HALF_DIV << (out_up - EXP_W'(1)));
              div_den <= UNIT_DIV << (out_up - EXP_W'(1));
              state   <= ST_MANT;
            end
          end else if (out_up == EXP_TOP) begin
            out_err <= 1'b1;
            out_up  <= '0;
            state   <= ST_FIN;
          end else begin
            out_up  <= out_up + EXP_W'(1);
            div_go  <= 1'b1;
            div_num <= (BASE_NUM << (out_up + EXP_W'(1))) + (tick_r >> 1);
            div_den <= tick_r;
            state   <= ST_SRCH_UP;
          end
        end
        ST_MANT: if (div_done) begin
          out_mant <= q[MANT_W-1:0];
          state    <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the result strobe never lasts two cycles
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R1: a taken request closes the input until the result
  assert_busy_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3: a bad level is answered on the very next cycle with an error
  assert_level_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (int'(in_level) >= N_LVL)) |=>
      (out_valid && out_err && out_mant == '0));

  // R9: an error result carries no parameters
  assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_up == '0 && out_down == '0 && out_mant == '0));

  // R10: only one of the two exponents is ever in use
  assert_one_exp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_up == '0 || out_down == '0));
endmodule

// File: tb/shp_rate_conv_tb_top.sv
module shp_rate_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_rate = '0;
  logic [2:0]  in_level = '0;
  logic        out_valid;
  logic [7:0]  out_mant;
  logic [3:0]  out_up, out_down;
  logic        out_err;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  shp_rate_conv dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rate(in_rate), .in_level(in_level), .out_valid(out_valid),
    .out_mant(out_mant), .out_up(out_up), .out_down(out_down), .out_err(out_err)
  );

  // behavioural reference model
  int    exp_b[$], exp_u[$], exp_s[$], exp_e[$];
  string exp_tag[$];
  string cur_tag = "R4";
  logic  m_busy = 1'b0;
  logic  done_seen = 1'b0;
  logic  model_on = 1'b0;

  function automatic void ref_calc(input longint req, input int lvl,
                                   output int b, output int u, output int s, output int e);
    longint tick, rate, d;
    b = 0; u = 0; s = 0; e = 0;
    if (lvl >= 4) begin e = 1; return; end
    case (lvl)
      0: tick = 1536;
      1: tick = 192;
      2: tick = 48;
      default: tick = 1536;
    endcase
    rate = (1008000 + tick / 2 - 1) / tick;
    if (rate == req) begin
      b = 126;
    end else if (rate > req) begin
      while (rate > req) begin
        if (s == 15) begin e = 1; break; end
        s++;
        rate = 1008000 / (tick << s);
      end
      if (e == 0)
        b = (rate == req) ? 126 : int'((((req * tick) << s) + 4000) / 8000) & 255;
    end else begin
      while (rate < req) begin
        if (u == 15) begin e = 1; break; end
        u++;
        rate = ((longint'(1008000) << u) + tick / 2) / tick;
      end
      if (e == 0 && rate != req) begin
        u--;
        d = longint'(8000) << u;
        b = int'((req * tick + d / 2) / d) & 255;
      end else if (e == 0) begin
        b = 126;
      end
    end
    if (e != 0) begin b = 0; u = 0; s = 0; end
  endfunction

  // accept side of the model
  always @(posedge clk) begin
    if (model_on) begin
      if (in_valid && !m_busy) begin
        int b, u, s, e;
        ref_calc(longint'(in_rate), int'(in_level), b, u, s, e);
        exp_b.push_back(b); exp_u.push_back(u); exp_s.push_back(s);
        exp_e.push_back(e); exp_tag.push_back(cur_tag);
        m_busy <= 1'b1;
      end else if (done_seen) begin
        m_busy <= 1'b0;
      end
    end
  end

  // compare side, every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      if (in_ready !== !m_busy) begin
        total++; bad++;
        $display("FAIL R1: in_ready=%0b expected=%0b at cycle %0d", in_ready, !m_busy, cycles);
      end
      done_seen = out_valid;
      if (out_valid) begin
        total++;
        if (exp_b.size() == 0) begin
          bad++;
          $display("FAIL R2: unexpected result mant=%0d expected no result", out_mant);
        end else begin
          int b, u, s, e;
          string t;
          b = exp_b.pop_front(); u = exp_u.pop_front(); s = exp_s.pop_front();
          e = exp_e.pop_front(); t = exp_tag.pop_front();
          if (int'(out_mant) != b || int'(out_up) != u || int'(out_down) != s || int'(out_err) != e) begin
            bad++;
            $display("FAIL %s: got mant=%0d up=%0d down=%0d err=%0b expected mant=%0d up=%0d down=%0d err=%0b",
                     t, out_mant, out_up, out_down, out_err, b, u, s, e);
          end
        end
      end
    end
  end

  task automatic wait_idle();
    while (exp_b.size() != 0 || m_busy || done_seen) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] rate, input logic [2:0] lvl, input string tag);
    @(negedge clk);
    cur_tag  = tag;
    in_rate  = rate;
    in_level = lvl;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    total++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R10: in_ready=%0b out_valid=%0b expected 1 0", in_ready, out_valid);
    end
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    // R4: baseline hits for each level
    run(32'd656,   3'd0, "R4");
    run(32'd5250,  3'd1, "R4");
    run(32'd21000, 3'd2, "R4");
    run(32'd656,   3'd3, "R4");
    // R5 / R6: down search with rounded and exact mantissa
    run(32'd100,   3'd0, "R5");
    run(32'd1000,  3'd2, "R6");
    run(32'd0,     3'd1, "R5");
    run(32'd3000,  3'd1, "R6");
    // R7 / R8: up search with decrement
    run(32'd100000, 3'd2, "R7");
    run(32'd1000,   3'd0, "R8");
    run(32'd40000,  3'd1, "R8");
    run(32'd25000,  3'd2, "R7");
    // R9: no convergence at exponent 15
    run(32'hFFFF_FFFF, 3'd2, "R9");
    run(32'd50000000,  3'd0, "R9");
    // R3: levels out of range
    run(32'd5, 3'd5, "R3");
    run(32'd0, 3'd7, "R3");

    // R1: requests offered while busy are ignored
    @(negedge clk);
    cur_tag = "R1"; in_rate = 32'd777; in_level = 3'd1; in_valid = 1'b1;
    @(negedge clk);
    in_rate = 32'd9; in_level = 3'd6;
    repeat (30) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    repeat (80) @(negedge clk);
    total++;
    if (exp_b.size() != 0) begin
      bad++;
      $display("FAIL R1: pending results=%0d expected 0", exp_b.size());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    bad++; total++;
    $display("FAIL R2: watchdog expired at cycle=%0d expected completion", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule